// File: doc/BRIEF.md
# Timer Configuration Register Block with Enable Lock

This block holds the configuration of a timer peripheral: one main control word and four auxiliary configuration words. Writes arrive over a simple address, write-data and write-strobe port, and every register can be read back combinationally. The stored configuration drives the counter logic directly through dedicated output ports.

Most configuration may change only while the peripheral is fully disabled. A change to the enable bit starts a fixed-length synchronization window, and a busy flag is raised for that window. The effective enable output follows the written enable bit only when the window closes. The lock is in force while the stored enable bit is 1 or while a window is open. Software that wants to reconfigure therefore clears enable, waits for busy to drop, and then writes the locked fields.

Top module: `tcfg_regs`

## Requirements
- R1: After reset every register reads zero, and en_o, busy_o and all configuration outputs are 0.
- R2: While unlocked (stored enable 0 and busy_o low), a write to address 0 stores all control fields. The layout is: bit 0 enable, bit 1 debug-run, bits 3:2 mode, bits 7:4 prescale, bit 8 clear-on-match, bit 9 clock format, bit 10 GP-reset-on-tamper.
- R3: The auxiliary registers are second control (address 1), event control (address 2), tamper control A (address 3) and tamper control B (address 4). A write to one of them takes effect only while unlocked and is ignored otherwise.
- R4: A write to address 0 that sets enable from the unlocked state also stores the locked fields given in that same write.
- R5: While locked, a write to address 0 leaves mode, prescale, clear-on-match, clock format and GP-reset-on-tamper unchanged. Enable and debug-run still take the written values.
- R6: A write that clears enable changes only enable and debug-run. The locked fields keep their values, and they stay locked until busy_o drops.
- R7: A write to address 0 whose bit 0 differs from the stored enable raises busy_o for exactly SYNC_CYCLES cycles, starting the cycle after the write. Another such write during the window restarts it. A write that leaves bit 0 unchanged starts no window.
- R8: en_o takes the stored enable value in the same cycle that busy_o falls, and changes at no other time.
- R9: Reading address 5 returns busy in bit 0 and the effective enable in bit 1. Writes to address 5 are ignored, and addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i |
| en_o | output | 1 | Effective (synchronized) enable |
| busy_o | output | 1 | Enable synchronization pending |
| dbg_run_o | output | 1 | Debug-run control |
| mode_o | output | 2 | Operating mode |
| presc_o | output | 4 | Prescaler select |
| clr_match_o | output | 1 | Clear counter on match |
| clk_fmt_o | output | 1 | Clock representation select |
| gp_rst_o | output | 1 | Reset GP registers on tamper |
| ctrl2_o | output | DW | Second control register |
| evt_o | output | DW | Event control register |
| tamp_a_o | output | DW | Tamper control A |
| tamp_b_o | output | DW | Tamper control B |

## Verification
The assertions check on every cycle that the locked outputs and the auxiliary registers hold steady while locked. They also check that debug-run always follows a control write, that an enable-changing write raises busy, that en_o moves only when busy falls, and that a busy window lasts at least SYNC_CYCLES. Some properties can only be shown by the bench's scenarios against its reference model: the exact window length with and without a restart, the locked fields surviving a disabling write, and writes during the disable window being dropped while writes after it are accepted. The bench also covers readback of every address, status writes being ignored, and the reset state.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 11;

  typedef struct packed {
    logic       gp_rst;
    logic       clk_fmt;
    logic       clr_match;
    logic [3:0] presc;
    logic [1:0] mode;
    logic       dbg_run;
    logic       en;
  } ctrl_t;

  // bits that are frozen while locked
  localparam logic [CTRL_W-1:0] PROT_MASK = 11'b111_1111_1100;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL2 = 3'd1;
  localparam logic [ADDR_W-1:0] A_EVT   = 3'd2;
  localparam logic [ADDR_W-1:0] A_TAMPA = 3'd3;
  localparam logic [ADDR_W-1:0] A_TAMPB = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;
endpackage

// File: rtl/tcfg_sync.sv
module tcfg_sync #(
  parameter int SYNC_CYCLES = 4,
  localparam int CW = $clog2(SYNC_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic en_req_i,
  output logic busy_o,
  output logic en_eff_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      en_eff_o <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(SYNC_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) en_eff_o <= en_req_i;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/tcfg_ctrl_reg.sv
module tcfg_ctrl_reg
  import tcfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              locked_i,
  output ctrl_t             q_o,
  output logic              en_flip_o
);
  logic [CTRL_W-1:0] q_v, nxt;

  assign q_v       = q_o;
  assign en_flip_o = we_i && (wdata_i[0] != q_o.en);

  always_comb begin
    nxt = q_v;
    if (we_i) nxt = locked_i ? ((q_v & PROT_MASK) | (wdata_i & ~PROT_MASK)) : wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= ctrl_t'(nxt);
  end
endmodule

// File: rtl/tcfg_aux_regs.sv
module tcfg_aux_regs #(
  parameter int N  = 4,
  parameter int DW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         sel_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 locked_i,
  output logic [N-1:0][DW-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    q_o[i] <= '0;
      else if (sel_i[i] && !locked_i) q_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/tcfg_regs.sv
module tcfg_regs
  import tcfg_pkg::*;
#(
  parameter int DW          = 32,
  parameter int SYNC_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              en_o,
  output logic              busy_o,
  output logic              dbg_run_o,
  output logic [1:0]        mode_o,
  output logic [3:0]        presc_o,
  output logic              clr_match_o,
  output logic              clk_fmt_o,
  output logic              gp_rst_o,
  output logic [DW-1:0]     ctrl2_o,
  output logic [DW-1:0]     evt_o,
  output logic [DW-1:0]     tamp_a_o,
  output logic [DW-1:0]     tamp_b_o
);
  localparam int N_AUX = 4;

  ctrl_t                     ctrl_q;
  logic                      en_req, en_flip, locked;
  logic [N_AUX-1:0]          aux_sel;
  logic [N_AUX-1:0][DW-1:0]  aux_q;

  assign en_req = ctrl_q.en;
  // disabled only once stored enable is 0 and the window has closed
  assign locked = en_req | busy_o;

  tcfg_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i && (addr_i == A_CTRL)),
    .wdata_i   (wdata_i[CTRL_W-1:0]),
    .locked_i  (locked),
    .q_o       (ctrl_q),
    .en_flip_o (en_flip)
  );

  tcfg_sync #(.SYNC_CYCLES(SYNC_CYCLES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (en_flip),
    .en_req_i (en_req),
    .busy_o   (busy_o),
    .en_eff_o (en_o)
  );

  for (genvar i = 0; i < N_AUX; i++) begin : g_sel
    assign aux_sel[i] = we_i && (addr_i == ADDR_W'(i + 1));
  end

  tcfg_aux_regs #(.N(N_AUX), .DW(DW)) u_aux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (aux_sel),
    .wdata_i  (wdata_i),
    .locked_i (locked),
    .q_o      (aux_q)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) rdata_o = DW'(ctrl_q);
    if (addr_i == A_STAT) rdata_o = DW'({en_o, busy_o});
    for (int i = 0; i < N_AUX; i++)
      if (addr_i == ADDR_W'(i + 1)) rdata_o = aux_q[i];
  end

  assign dbg_run_o   = ctrl_q.dbg_run;
  assign mode_o      = ctrl_q.mode;
  assign presc_o     = ctrl_q.presc;
  assign clr_match_o = ctrl_q.clr_match;
  assign clk_fmt_o   = ctrl_q.clk_fmt;
  assign gp_rst_o    = ctrl_q.gp_rst;
  assign ctrl2_o     = aux_q[0];
  assign evt_o       = aux_q[1];
  assign tamp_a_o    = aux_q[2];
  assign tamp_b_o    = aux_q[3];
endmodule

// File: rtl/tcfg_chk.sv
module tcfg_chk
  import tcfg_pkg::*;
#(
  parameter int DW          = 32,
  parameter int SYNC_CYCLES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DW-1:0]     wdata_i,
  input logic              en_o,
  input logic              busy_o,
  input logic              dbg_run_o,
  input logic [1:0]        mode_o,
  input logic [3:0]        presc_o,
  input logic              clr_match_o,
  input logic              clk_fmt_o,
  input logic              gp_rst_o,
  input logic [DW-1:0]     ctrl2_o,
  input logic [DW-1:0]     evt_o,
  input logic [DW-1:0]     tamp_a_o,
  input logic [DW-1:0]     tamp_b_o,
  input logic              en_req
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 0;
    else if (busy_o) run_q <= (run_q < SYNC_CYCLES) ? run_q + 1 : run_q;
    else             run_q <= 0;
  end

  // R5
  prot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o || busy_o) |=> $stable({mode_o, presc_o, clr_match_o, clk_fmt_o, gp_rst_o}));

  // R3
  aux_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o || busy_o) |=> $stable({ctrl2_o, evt_o, tamp_a_o, tamp_b_o}));

  // R3
  aux_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_o && !busy_o && we_i && addr_i == A_EVT) |=> (evt_o == $past(wdata_i)));

  // R5
  dbg_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL) |=> (dbg_run_o == $past(wdata_i[1])));

  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL && wdata_i[0] != en_req) |=> busy_o);

  // R8
  en_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_o) |-> $fell(busy_o));

  // R7
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q >= SYNC_CYCLES));
endmodule

bind tcfg_regs tcfg_chk #(.DW(DW), .SYNC_CYCLES(SYNC_CYCLES)) u_chk (.*);

// File: tb/sim_tcfg_regs.sv
module sim_tcfg_regs;
  localparam int DW   = 32;
  localparam int SYNC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, ctrl2, evt, tampa, tampb;
  logic          en, busy, dbg, clrm, cfmt, gpr;
  logic [1:0]    mode;
  logic [3:0]    presc;

  int checks = 0, fails = 0;
  string cur = "R1";
  bit done = 0;

  // reference model state
  logic [10:0]   m_ctrl = '0;
  logic [DW-1:0] m_aux [4];
  bit            m_en = 0;
  int            m_cnt = 0;

  always #10 clk = ~clk;

  tcfg_regs #(.DW(DW), .SYNC_CYCLES(SYNC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .en_o(en), .busy_o(busy), .dbg_run_o(dbg), .mode_o(mode),
    .presc_o(presc), .clr_match_o(clrm), .clk_fmt_o(cfmt), .gp_rst_o(gpr),
    .ctrl2_o(ctrl2), .evt_o(evt), .tamp_a_o(tampa), .tamp_b_o(tampb)
  );

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return DW'(m_ctrl);
      3'd1, 3'd2, 3'd3, 3'd4: return m_aux[a - 1];
      3'd5: return DW'({m_en, m_cnt != 0});
      default: return '0;
    endcase
  endfunction

  initial for (int i = 0; i < 4; i++) m_aux[i] = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = '0; m_en = 0; m_cnt = 0;
      for (int i = 0; i < 4; i++) m_aux[i] = '0;
    end else begin
      bit locked;
      int nc;
      bit ne;
      locked = m_ctrl[0] || (m_cnt != 0);
      nc = m_cnt; ne = m_en;
      if (m_cnt > 0) begin
        nc = m_cnt - 1;
        if (nc == 0) ne = m_ctrl[0];
      end
      if (we) begin
        if (addr == 3'd0) begin
          if (wdata[0] != m_ctrl[0]) begin nc = SYNC; ne = m_en; end
          m_ctrl = locked ? {m_ctrl[10:2], wdata[1:0]} : wdata[10:0];
        end else if (addr >= 3'd1 && addr <= 3'd4 && !locked) begin
          m_aux[addr - 1] = wdata;
        end
      end
      m_cnt = nc; m_en = ne;
      #5;
      chk("R8", "en_o", DW'(en), DW'(m_en));
      chk("R7", "busy_o", DW'(busy), DW'(m_cnt != 0));
      chk(cur, "ctrl fields", DW'({gpr, cfmt, clrm, presc, mode, dbg}), DW'(m_ctrl[10:1]));
      chk(cur, "ctrl2_o", ctrl2, m_aux[0]);
      chk(cur, "evt_o", evt, m_aux[1]);
      chk(cur, "tamp_a_o", tampa, m_aux[2]);
      chk(cur, "tamp_b_o", tampb, m_aux[3]);
      chk(cur, "rdata_o", rdata, exp_rd(addr));
    end
  end

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    idle(3);
    // R1: reset state visible before release
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R1", "rdata_o in reset", rdata, '0);
    end
    chk("R1", "en/busy in reset", DW'({en, busy}), '0);
    chk("R1", "fields in reset", DW'({gpr, cfmt, clrm, presc, mode, dbg}), '0);
    addr = '0;
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    cur = "R2"; wr(0, 32'h0000_05A8); wr(0, 32'h0000_02B6); idle(1);
    cur = "R3"; wr(1, 32'hCAFE_0001); wr(2, 32'h1234_5678);
    wr(3, 32'hA5A5_5A5A); wr(4, 32'h0F0F_F0F0); idle(1);
    cur = "R4"; wr(0, 32'h0000_06D1); idle(SYNC + 2);
    cur = "R5"; wr(0, 32'h0000_0003); wr(1, 32'hDEAD_BEEF);
    wr(4, 32'h1111_1111); wr(0, 32'h0000_07FD); idle(2);
    cur = "R6"; wr(0, 32'h0000_07FE); wr(0, 32'h0000_0154);
    wr(2, 32'h7777_7777); idle(SYNC + 2);
    cur = "R2"; wr(0, 32'h0000_00A8);
    cur = "R3"; wr(2, 32'h8888_0000); idle(1);
    cur = "R7"; wr(0, 32'h0000_0001); idle(1); wr(0, 32'h0000_0000);
    idle(SYNC + 2); wr(0, 32'h0000_0000); idle(2);
    wr(0, 32'h0000_0001); idle(SYNC + 1); wr(0, 32'h0000_0001); idle(2);
    wr(0, 32'h0000_0000); idle(SYNC + 2);
    cur = "R9"; wr(5, 32'hFFFF_FFFF);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); addr = 3'(a);
    end
    wr(0, 32'h0000_0001); addr = 3'd5; idle(SYNC + 2);
    done = 1;
    summary();
  end
endmodule